// File: doc/BRIEF.md
# Windowed Register File with Overlapping Call Frames

This block is a multi-ported register file whose 32 architectural register addresses are resolved through a current window pointer. A procedure sees eight global registers, which every window shares. It also sees three groups of eight windowed registers: incoming arguments, private locals and outgoing arguments. A call strobe moves the pointer to a fresh window and a return strobe moves it back. Adjacent windows overlap, so the values a caller places in its outgoing group appear in the callee's incoming group without any copying.

The windows form a ring of `NWIN` frames. One frame is held back as a reserved boundary by a saved window pointer. A call that would step onto that frame raises an overflow flag and leaves the pointer where it is. A return that would step onto it raises an underflow flag and also leaves the pointer in place. Moving frames to memory and back is left to surrounding logic, which watches the flags. Reads are combinational on two independent ports, and writes land on the clock edge through one port.

Top module: `rwin_file`

## Requirements
- R1: After reset the window pointer output is 0, every architectural address reads 0 on both ports, and both flags are low.
- R2: Addresses 0..7 (address bits [4:3] = 00) select one set of eight global registers that reads and writes identically from every window.
- R3: Addresses 16..23 (bits [4:3] = 10) select registers private to the current window. A write there is not visible from any other window.
- R4: Addresses 8..15 (bits [4:3] = 01) of window w and addresses 24..31 (bits [4:3] = 11) of window (w-1) mod NWIN share storage: outgoing register 8+k of a caller is incoming register 24+k of its callee.
- R5: A call strobe alone moves the pointer from w to (w-1) mod NWIN. A return strobe alone moves it to (w+1) mod NWIN. The pointer changes on the clock edge.
- R6: The saved window pointer is reset to window 1 and never moves. A lone call while (w-1) mod NWIN equals it drives the overflow output high in that cycle, and the pointer stays unchanged.
- R7: A lone return while (w+1) mod NWIN equals the saved window pointer drives the underflow output high in that cycle, and the pointer stays unchanged.
- R8: Starting from reset, exactly NWIN-2 consecutive calls succeed before overflow.
- R9: Read data follows the read address combinationally. A write appears only after the rising edge, so a same-cycle read of the written address returns the old value.
- R10: A write issued in the same cycle as a call or return uses the window that was current before the move.
- R11: Call and return asserted together leave the pointer unchanged and raise neither flag.
- R12: With the write enable low, no register changes, whatever the write address and data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| call_i | input | 1 | Procedure call strobe (move to callee window) |
| ret_i | input | 1 | Procedure return strobe (move to caller window) |
| wr_en | input | 1 | Write enable |
| wr_addr | input | 5 | Architectural write address |
| wr_data | input | DW | Write data |
| rd_addr_a | input | 5 | Architectural read address, port A |
| rd_data_a | output | DW | Read data, port A |
| rd_addr_b | input | 5 | Architectural read address, port B |
| rd_data_b | output | DW | Read data, port B |
| win_ptr | output | WPW | Current window pointer |
| ovf | output | 1 | Call refused: window overflow |
| unf | output | 1 | Return refused: window underflow |

## Verification
A pointer that drifts by one frame shows up at the ports as soon as the next read. Incoming registers then return the values another frame wrote, and locals read as zero or as a neighbour's data. A wrong overlap mapping hides until the first call after a write to an outgoing register, so the bench fills every address in every reachable window and reads all of them back after each move. A wrong boundary comparison shows in the same cycle as the strobe through the flags, and one edge later through an unchanged or wrongly moved pointer.

// File: rtl/rwin_pkg.sv
package rwin_pkg;
  localparam int AW    = 5;
  localparam int NGLB  = 8;
  localparam int GRPSZ = 8;
  localparam int FRAME = 2 * GRPSZ;

  typedef enum logic [1:0] {
    GRP_GLOBAL = 2'b00,
    GRP_OUT    = 2'b01,
    GRP_LOCAL  = 2'b10,
    GRP_IN     = 2'b11
  } grp_e;
endpackage

// File: rtl/rwin_rst_sync.sv
module rwin_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [1:0] stage_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stage_q <= 2'b00;
    else        stage_q <= {stage_q[0], 1'b1};
  end

  assign rst_sync_n = stage_q[1];
endmodule

// File: rtl/rwin_ptr.sv
module rwin_ptr #(
  parameter int NWIN = 8,
  parameter int WPW  = 3
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           call_i,
  input  logic           ret_i,
  output logic [WPW-1:0] cwp_o,
  output logic [WPW-1:0] swp_o,
  output logic           ovf_o,
  output logic           unf_o
);
  localparam logic [WPW-1:0] LAST = WPW'(NWIN - 1);
  localparam logic [WPW-1:0] RSVD = WPW'(1);

  logic [WPW-1:0] cwp_q, cwp_d, swp_q, swp_d;
  logic [WPW-1:0] win_dn, win_up;
  logic           call_only, ret_only, cwp_en;

  always_comb begin
    win_dn    = (cwp_q == '0)   ? LAST : cwp_q - WPW'(1);
    win_up    = (cwp_q == LAST) ? '0   : cwp_q + WPW'(1);
    call_only = call_i & ~ret_i;
    ret_only  = ret_i & ~call_i;
    ovf_o     = call_only & (win_dn == swp_q);
    unf_o     = ret_only  & (win_up == swp_q);
    cwp_en    = (call_only & ~ovf_o) | (ret_only & ~unf_o);
    cwp_d     = call_only ? win_dn : win_up;
    swp_d     = swp_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cwp_q <= '0;
      swp_q <= RSVD;
    end else begin
      if (cwp_en) cwp_q <= cwp_d;
      swp_q <= swp_d;
    end
  end

  assign cwp_o = cwp_q;
  assign swp_o = swp_q;
endmodule

// File: rtl/rwin_map.sv
module rwin_map
  import rwin_pkg::*;
#(
  parameter int NWIN = 8,
  parameter int WPW  = 3,
  parameter int PW   = 8
) (
  input  logic [WPW-1:0] cwp_i,
  input  logic [AW-1:0]  arch_i,
  output logic [PW-1:0]  phys_o
);
  grp_e grp;
  int   off, win, idx;

  always_comb begin
    grp = grp_e'(arch_i[4:3]);
    off = int'(arch_i[2:0]);
    win = int'(cwp_i);
    case (grp)
      GRP_GLOBAL: idx = off;
      GRP_OUT:    idx = NGLB + ((win == 0) ? NWIN - 1 : win - 1) * FRAME + off;
      GRP_LOCAL:  idx = NGLB + win * FRAME + GRPSZ + off;
      default:    idx = NGLB + win * FRAME + off;
    endcase
    phys_o = PW'(idx);
  end
endmodule

// File: rtl/rwin_store.sv
module rwin_store #(
  parameter int DW    = 32,
  parameter int NPHYS = 136,
  parameter int PW    = 8,
  parameter int NRD   = 2
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   wr_en,
  input  logic [PW-1:0]          wr_idx,
  input  logic [DW-1:0]          wr_data,
  input  logic [NRD-1:0][PW-1:0] rd_idx,
  output logic [NRD-1:0][DW-1:0] rd_data
);
  logic [DW-1:0] mem_q [NPHYS];

  for (genvar e = 0; e < NPHYS; e++) begin : g_ent
    logic ent_en;
    assign ent_en = wr_en & (wr_idx == PW'(e));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      mem_q[e] <= '0;
      else if (ent_en) mem_q[e] <= wr_data;
    end
  end

  for (genvar p = 0; p < NRD; p++) begin : g_rd
    always_comb begin
      rd_data[p] = '0;
      for (int e = 0; e < NPHYS; e++) begin
        if (rd_idx[p] == PW'(e)) rd_data[p] = mem_q[e];
      end
    end
  end
endmodule

// File: rtl/rwin_file.sv
module rwin_file
  import rwin_pkg::*;
#(
  parameter  int NWIN = 8,
  parameter  int DW   = 32,
  localparam int WPW  = (NWIN > 1) ? $clog2(NWIN) : 1
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           call_i,
  input  logic           ret_i,
  input  logic           wr_en,
  input  logic [4:0]     wr_addr,
  input  logic [DW-1:0]  wr_data,
  input  logic [4:0]     rd_addr_a,
  output logic [DW-1:0]  rd_data_a,
  input  logic [4:0]     rd_addr_b,
  output logic [DW-1:0]  rd_data_b,
  output logic [WPW-1:0] win_ptr,
  output logic           ovf,
  output logic           unf
);
  localparam int NPHYS = NGLB + NWIN * FRAME;
  localparam int PW    = $clog2(NPHYS);
  localparam int NMAP  = 3;

  logic                   rst_sync_n;
  logic [WPW-1:0]         cur_win, sav_win;
  logic [NMAP-1:0][AW-1:0] arch_addr;
  logic [NMAP-1:0][PW-1:0] phys_idx;
  logic [1:0][PW-1:0]     rd_idx;
  logic [1:0][DW-1:0]     rd_data;

  rwin_rst_sync u_rst (
    .clk(clk), .rst_n(rst_n), .rst_sync_n(rst_sync_n)
  );

  rwin_ptr #(.NWIN(NWIN), .WPW(WPW)) u_ptr (
    .clk(clk), .rst_n(rst_sync_n), .call_i(call_i), .ret_i(ret_i),
    .cwp_o(cur_win), .swp_o(sav_win), .ovf_o(ovf), .unf_o(unf)
  );

  assign arch_addr[0] = wr_addr;
  assign arch_addr[1] = rd_addr_a;
  assign arch_addr[2] = rd_addr_b;

  for (genvar m = 0; m < NMAP; m++) begin : g_map
    rwin_map #(.NWIN(NWIN), .WPW(WPW), .PW(PW)) u_map (
      .cwp_i(cur_win), .arch_i(arch_addr[m]), .phys_o(phys_idx[m])
    );
  end

  assign rd_idx[0] = phys_idx[1];
  assign rd_idx[1] = phys_idx[2];

  rwin_store #(.DW(DW), .NPHYS(NPHYS), .PW(PW), .NRD(2)) u_store (
    .clk(clk), .rst_n(rst_sync_n), .wr_en(wr_en), .wr_idx(phys_idx[0]),
    .wr_data(wr_data), .rd_idx(rd_idx), .rd_data(rd_data)
  );

  assign rd_data_a = rd_data[0];
  assign rd_data_b = rd_data[1];
  assign win_ptr   = cur_win;
endmodule

// File: rtl/rwin_file_chk.sv
module rwin_file_chk #(
  parameter  int NWIN = 8,
  localparam int WPW  = (NWIN > 1) ? $clog2(NWIN) : 1
) (
  input logic           clk,
  input logic           rst_n,
  input logic           call_i,
  input logic           ret_i,
  input logic [WPW-1:0] cwp,
  input logic [WPW-1:0] swp,
  input logic           ovf,
  input logic           unf
);
  localparam logic [WPW-1:0] LAST = WPW'(NWIN - 1);

  // R5
  call_dec_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (call_i && !ret_i && !ovf) |=>
      cwp == (($past(cwp) == '0) ? LAST : $past(cwp) - WPW'(1)));

  // R5
  ret_inc_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ret_i && !call_i && !unf) |=>
      cwp == (($past(cwp) == LAST) ? '0 : $past(cwp) + WPW'(1)));

  // R6
  no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ovf |=> $stable(cwp));

  // R7
  no_underflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    unf |=> $stable(cwp));

  // R11
  both_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (call_i && ret_i) |-> (!ovf && !unf));

  // R11
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (call_i == ret_i) |=> $stable(cwp));

  // R6
  swp_fixed_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $stable(swp) && (cwp != swp));
endmodule

bind rwin_file rwin_file_chk #(.NWIN(NWIN)) u_chk (
  .clk(clk), .rst_n(rst_sync_n), .call_i(call_i), .ret_i(ret_i),
  .cwp(cur_win), .swp(sav_win), .ovf(ovf), .unf(unf)
);

// File: tb/rwin_file_tb.sv
module rwin_file_tb;
  localparam int NWIN = 4;
  localparam int DW   = 32;
  localparam int WPW  = 2;
  localparam int RSVD = 1;

  logic           clk = 1'b0;
  logic           rst_n = 1'b0;
  logic           call_i = 1'b0, ret_i = 1'b0, wr_en = 1'b0;
  logic [4:0]     wr_addr = '0, rd_addr_a = '0, rd_addr_b = '0;
  logic [DW-1:0]  wr_data = '0;
  logic [DW-1:0]  rd_data_a, rd_data_b;
  logic [WPW-1:0] win_ptr;
  logic           ovf, unf;

  int checks = 0, failures = 0;
  bit done = 0;

  logic [DW-1:0] m_glb [8];
  logic [DW-1:0] m_in  [NWIN][8];
  logic [DW-1:0] m_loc [NWIN][8];
  int mcwp = 0;

  always #10 clk = ~clk;

  rwin_file #(.NWIN(NWIN), .DW(DW)) u_dut (
    .clk(clk), .rst_n(rst_n), .call_i(call_i), .ret_i(ret_i),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr_a(rd_addr_a), .rd_data_a(rd_data_a),
    .rd_addr_b(rd_addr_b), .rd_data_b(rd_data_b),
    .win_ptr(win_ptr), .ovf(ovf), .unf(unf)
  );

  function automatic int dn(int w); return (w + NWIN - 1) % NWIN; endfunction
  function automatic int up(int w); return (w + 1) % NWIN; endfunction

  function automatic logic [DW-1:0] m_read(int w, int a);
    if (a < 8)       return m_glb[a];
    else if (a < 16) return m_in[dn(w)][a-8];
    else if (a < 24) return m_loc[w][a-16];
    else             return m_in[w][a-24];
  endfunction

  task automatic m_write(int w, int a, logic [DW-1:0] v);
    if (a < 8)       m_glb[a] = v;
    else if (a < 16) m_in[dn(w)][a-8] = v;
    else if (a < 24) m_loc[w][a-16] = v;
    else             m_in[w][a-24] = v;
  endtask

  task automatic chk(bit ok, string tag, logic [DW-1:0] act, logic [DW-1:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic string grp_tag(int a);
    if (a < 8)       return "R2 global";
    else if (a < 16) return "R4 out";
    else if (a < 24) return "R3 local";
    else             return "R4 in";
  endfunction

  // Sweep all 32 addresses on both ports against the model.
  task automatic read_all();
    for (int a = 0; a < 32; a++) begin
      @(negedge clk);
      rd_addr_a = 5'(a);
      rd_addr_b = 5'(31 - a);
      #2;
      chk(rd_data_a === m_read(mcwp, a), grp_tag(a), rd_data_a, m_read(mcwp, a));
      chk(rd_data_b === m_read(mcwp, 31 - a), grp_tag(31 - a), rd_data_b,
          m_read(mcwp, 31 - a));
    end
  endtask

  // One cycle of stimulus; flags checked mid-cycle, model updated after edge.
  task automatic step(bit c, bit r, bit we, int wa, logic [DW-1:0] wd, string tag);
    bit eo, eu;
    @(negedge clk);
    call_i = c; ret_i = r; wr_en = we; wr_addr = 5'(wa); wr_data = wd;
    eo = c && !r && (dn(mcwp) == RSVD);
    eu = r && !c && (up(mcwp) == RSVD);
    #5;
    chk(ovf === eo, {tag, " ovf"}, DW'(ovf), DW'(eo));
    chk(unf === eu, {tag, " unf"}, DW'(unf), DW'(eu));
    @(posedge clk);
    if (we) m_write(mcwp, wa, wd);
    if (c && !r && !eo) mcwp = dn(mcwp);
    if (r && !c && !eu) mcwp = up(mcwp);
    #1;
    call_i = 0; ret_i = 0; wr_en = 0;
    chk(win_ptr === WPW'(mcwp), {tag, " ptr"}, DW'(win_ptr), DW'(mcwp));
  endtask

  task automatic fill_window();
    for (int a = 0; a < 32; a++)
      step(0, 0, 1, a, {8'h5A, 8'(mcwp), 8'h00, 8'(a)} ^ DW'(checks), "R2 fill");
  endtask

  initial begin
    #(20 * 200000);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 8; i++) begin
      m_glb[i] = '0;
      for (int w = 0; w < NWIN; w++) begin m_in[w][i] = '0; m_loc[w][i] = '0; end
    end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1 reset state
    #2;
    chk(win_ptr === '0, "R1 ptr", DW'(win_ptr), 0);
    chk(!ovf && !unf, "R1 flags", DW'({ovf, unf}), 0);
    read_all();

    // R9 same-cycle read sees old value, new value after edge
    @(negedge clk);
    rd_addr_a = 5'd17; wr_en = 1; wr_addr = 5'd17; wr_data = 32'hDEAD_0017;
    #2;
    chk(rd_data_a === '0, "R9 old", rd_data_a, 0);
    @(posedge clk); #1; wr_en = 0;
    m_write(mcwp, 17, 32'hDEAD_0017);
    chk(rd_data_a === 32'hDEAD_0017, "R9 new", rd_data_a, 32'hDEAD_0017);

    // R12 write enable low changes nothing
    @(negedge clk);
    wr_en = 0; wr_addr = 5'd17; wr_data = 32'h1111_2222; rd_addr_a = 5'd17;
    @(posedge clk); #1;
    chk(rd_data_a === 32'hDEAD_0017, "R12 no write", rd_data_a, 32'hDEAD_0017);

    // Fill window 0, descend with R5 / R4 sweeps
    fill_window();
    read_all();
    // R10 write together with call lands in pre-move window (out r9 of win 0)
    step(1, 0, 1, 9, 32'hCA11_0009, "R10 call+write");
    read_all();
    chk(m_read(mcwp, 25) === 32'hCA11_0009, "R10 model", m_read(mcwp, 25), 32'hCA11_0009);
    fill_window();
    step(1, 0, 0, 0, '0, "R5 call");
    read_all();
    fill_window();
    // R8 NWIN-2 calls done; next call overflows (R6)
    step(1, 0, 0, 0, '0, "R6 R8 overflow");
    chk(win_ptr === WPW'(2), "R8 ptr", DW'(win_ptr), 2);
    // R11 both strobes
    step(1, 1, 0, 0, '0, "R11 both");
    read_all();
    // Return path; R10 write together with return
    step(0, 1, 1, 20, 32'hBEEF_0020, "R10 ret+write");
    read_all();
    step(0, 1, 0, 0, '0, "R5 ret");
    read_all();
    // R7 underflow at window 0
    step(0, 1, 0, 0, '0, "R7 underflow");
    chk(win_ptr === '0, "R7 ptr", DW'(win_ptr), 0);
    step(1, 1, 1, 3, 32'h0303_0303, "R11 both write");
    read_all();
    // Wrap: call from 0 goes to NWIN-1 (R5)
    step(1, 0, 0, 0, '0, "R5 wrap");
    chk(win_ptr === WPW'(NWIN - 1), "R5 wrap ptr", DW'(win_ptr), NWIN - 1);
    read_all();

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule